// File: doc/BRIEF.md
# End-to-End CRC Flit Link with Watchdog Retransmission

This block guards 128-bit network flits between a sending node and a receiving node. On the sending side it accepts one flit at a time and attaches an 8-bit checksum to form a 136-bit protected word. It launches that word into the network, keeps a copy and arms a cycle-count watchdog. On the receiving side it checks each arriving word. A word that checks clean is handed to the local consumer and answered with a one-cycle acknowledge. A word that fails the check is dropped without any reply.

The sender learns of a loss only through silence. When the watchdog runs out before an acknowledge arrives, the sender first pulses a request asking the supply manager to raise the voltage. One cycle later it sends the stored word again and re-arms the watchdog. This repeats until an acknowledge ends the exchange. Routing, network flow control and voltage regulation sit outside the block. The network side is a plain valid/word pair in each direction, and the acknowledge is carried back by the surrounding fabric from `ack_out` to `ack_in`.

Top module: `e2e_crc_link`

## Requirements
- R1: While reset is high and on the first cycle after it falls, `src_ready` is 1, and `net_tx_valid`, `dst_valid`, `ack_out` and `vraise_req` are 0.
- R2: A flit accepted at a clock edge (`src_valid` and `src_ready` both 1) appears in the next cycle on `net_tx_word` with the flit in bits 135:8 and its checksum in bits 7:0. `net_tx_valid` is high for that cycle only. The checksum is the CRC with generator x^8+x^7+x^4+x^3+x+1 (0x9B), initial value 0x00, no reflection and no final XOR, taken over the flit from bit 127 down to bit 0.
- R3: From acceptance until an acknowledge is taken, `src_ready` is 0 and `src_valid` has no effect: no new word is sent.
- R4: A word on `net_rx_word` with `net_rx_valid` high and a correct checksum is presented in the next cycle on `dst_flit` (bits 135:8 of the word) with `dst_valid` 1. `ack_out` is high in that same cycle, for one cycle.
- R5: A word with a wrong checksum (any single-bit, checksum-field or 8-bit burst corruption) is discarded: `dst_valid` and `ack_out` stay 0.
- R6: With timeout value T ≥ 1 and no acknowledge, `vraise_req` is high for exactly one cycle, T cycles after the cycle in which the word was launched.
- R7: In the cycle after a `vraise_req` pulse, the same stored word is sent again with `net_tx_valid` high for one cycle, and the watchdog restarts. The pattern repeats every T+1 cycles.
- R8: An `ack_in` seen while a flit is outstanding ends the exchange: `src_ready` returns to 1 in the next cycle and no further pulse or resend follows. An acknowledge at the very edge where the watchdog would expire wins, and no `vraise_req` pulse is given.
- R9: `ack_in` while no flit is outstanding is ignored: `src_ready` stays 1 and nothing is sent or requested.
- R10: A timeout value of 0 behaves as 1: the pulse comes one cycle after launch.
- R11: While `dst_valid` is 1 and `dst_ready` is 0, `dst_flit` holds its value. A further good word arriving then is dropped without acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timeout_cycles | input | 16 | Watchdog limit in cycles (0 treated as 1) |
| src_valid | input | 1 | Sending node offers a flit |
| src_ready | output | 1 | Sender can take a flit (nothing outstanding) |
| src_flit | input | 128 | Flit from the sending node |
| net_tx_valid | output | 1 | Protected word launched this cycle |
| net_tx_word | output | 136 | Flit and checksum toward the network |
| net_rx_valid | input | 1 | Protected word arriving from the network |
| net_rx_word | input | 136 | Arriving flit and checksum |
| ack_out | output | 1 | One-cycle acknowledge for a clean word |
| ack_in | input | 1 | Acknowledge returned to the sender |
| dst_valid | output | 1 | Checked flit available to the consumer |
| dst_ready | input | 1 | Consumer takes the flit |
| dst_flit | output | 128 | Checked flit |
| vraise_req | output | 1 | One-cycle request to raise the supply voltage |

## Verification
The two sender functions that can land on the same edge are the returning acknowledge and the watchdog expiry. The bench places `ack_in` exactly on the edge where the count would run out. It then checks that no voltage request appears, that no resend follows and that `src_ready` comes back one cycle later. On the receiving side, a clean word can arrive while the output register is still held by a stalled consumer. The bench provokes this and checks that the held flit is unchanged and that no acknowledge is given.

// File: rtl/e2e_link_pkg.sv
package e2e_link_pkg;
  localparam int FLIT_W_DEF = 128;
  localparam int CRC_W_DEF  = 8;
  localparam int TMO_W_DEF  = 16;
  localparam logic [7:0] POLY_DEF = 8'h9B;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_WAIT  = 2'd1,
    TX_RAISE = 2'd2
  } tx_state_e;
endpackage

// File: rtl/crc_shift_chain.sv
// Unrolled MSB-first CRC, one shift stage per data bit, initial value zero.
module crc_shift_chain #(
  parameter int DATA_W = 128,
  parameter int CRC_W  = 8,
  parameter logic [CRC_W-1:0] POLY = 8'h9B
) (
  input  logic [DATA_W-1:0] data,
  output logic [CRC_W-1:0]  crc
);
  logic [CRC_W-1:0] stage [DATA_W+1];

  assign stage[0] = '0;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic fb;
    assign fb = stage[i][CRC_W-1] ^ data[DATA_W-1-i];
    assign stage[i+1] = {stage[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc = stage[DATA_W];
endmodule

// File: rtl/link_watchdog.sv
// Down-counting per-flit timer; expire is high during the last counted cycle.
module link_watchdog #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  logic [TMO_W-1:0] cnt;
  logic             running;
  logic [TMO_W-1:0] load_val;

  assign load_val = (limit == '0) ? TMO_W'(1) : limit;
  assign expire   = running && (cnt == TMO_W'(1)) && !stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (start) begin
      cnt     <= load_val;
      running <= 1'b1;
    end else if (stop) begin
      running <= 1'b0;
    end else if (running) begin
      cnt <= cnt - TMO_W'(1);
      if (cnt == TMO_W'(1)) running <= 1'b0;
    end
  end

  // R10: a running timer never holds a zero count
  p_count_nonzero_r10: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt != '0));
  // R6: an expiry always ends the run
  p_expire_ends_run_r6: assert property (@(posedge clk) disable iff (rst)
    (expire && !start) |=> !running);
endmodule

// File: rtl/link_sender.sv
module link_sender #(
  parameter int FLIT_W = 128,
  parameter int CRC_W  = 8,
  parameter logic [CRC_W-1:0] POLY = 8'h9B,
  parameter int TMO_W  = 16,
  localparam int WORD_W = FLIT_W + CRC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TMO_W-1:0]  timeout_cycles,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [FLIT_W-1:0] src_flit,
  output logic              tx_valid,
  output logic [WORD_W-1:0] tx_word,
  input  logic              ack_in,
  output logic              vraise
);
  import e2e_link_pkg::*;

  tx_state_e         state;
  logic              ready_q;
  logic              tx_valid_q;
  logic              vraise_q;
  logic [WORD_W-1:0] hold_word;
  logic [CRC_W-1:0]  src_crc;
  logic              accept;
  logic              ack_hit;
  logic              wd_start;
  logic              wd_expire;

  crc_shift_chain #(.DATA_W(FLIT_W), .CRC_W(CRC_W), .POLY(POLY)) u_crc (
    .data (src_flit),
    .crc  (src_crc)
  );

  assign accept   = src_valid && ready_q && (state == TX_IDLE);
  assign ack_hit  = ack_in && (state != TX_IDLE);
  assign wd_start = accept || ((state == TX_RAISE) && !ack_in);

  link_watchdog #(.TMO_W(TMO_W)) u_wd (
    .clk    (clk),
    .rst    (rst),
    .start  (wd_start),
    .stop   (ack_hit),
    .limit  (timeout_cycles),
    .expire (wd_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= TX_IDLE;
      ready_q    <= 1'b1;
      tx_valid_q <= 1'b0;
      vraise_q   <= 1'b0;
      hold_word  <= '0;
    end else begin
      tx_valid_q <= 1'b0;
      vraise_q   <= 1'b0;
      case (state)
        TX_IDLE: begin
          if (accept) begin
            hold_word  <= {src_flit, src_crc};
            tx_valid_q <= 1'b1;
            ready_q    <= 1'b0;
            state      <= TX_WAIT;
          end
        end
        TX_WAIT: begin
          if (ack_in) begin
            ready_q <= 1'b1;
            state   <= TX_IDLE;
          end else if (wd_expire) begin
            vraise_q <= 1'b1;
            state    <= TX_RAISE;
          end
        end
        TX_RAISE: begin
          if (ack_in) begin
            ready_q <= 1'b1;
            state   <= TX_IDLE;
          end else begin
            tx_valid_q <= 1'b1;
            state      <= TX_WAIT;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign src_ready = ready_q;
  assign tx_valid  = tx_valid_q;
  assign tx_word   = hold_word;
  assign vraise    = vraise_q;

  // R6: the voltage request is a single-cycle pulse
  p_raise_single_r6: assert property (@(posedge clk) disable iff (rst)
    vraise |=> !vraise);
  // R7: a request without acknowledge is followed by a resend of the same word
  p_resend_same_r7: assert property (@(posedge clk) disable iff (rst)
    (vraise && !ack_in) |=> (tx_valid && $stable(tx_word)));
  // R3: no flit is accepted while a word is on its way
  p_busy_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !src_ready);
  // R8: an acknowledge releases the sender and suppresses any request
  p_ack_releases_r8: assert property (@(posedge clk) disable iff (rst)
    (ack_in && !src_ready) |=> (src_ready && !vraise && !tx_valid));
endmodule

// File: rtl/link_receiver.sv
module link_receiver #(
  parameter int FLIT_W = 128,
  parameter int CRC_W  = 8,
  parameter logic [CRC_W-1:0] POLY = 8'h9B,
  localparam int WORD_W = FLIT_W + CRC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_word,
  output logic              ack_out,
  output logic              dst_valid,
  input  logic              dst_ready,
  output logic [FLIT_W-1:0] dst_flit
);
  logic [CRC_W-1:0]  residue;
  logic              word_good;
  logic              slot_free;
  logic              dst_valid_q;
  logic              ack_q;
  logic [FLIT_W-1:0] flit_q;

  // Running the CRC over flit and checksum together leaves a zero residue
  // exactly when the checksum matches.
  crc_shift_chain #(.DATA_W(WORD_W), .CRC_W(CRC_W), .POLY(POLY)) u_chk (
    .data (rx_word),
    .crc  (residue)
  );

  assign word_good = rx_valid && (residue == '0);
  assign slot_free = !dst_valid_q || dst_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_valid_q <= 1'b0;
      ack_q       <= 1'b0;
      flit_q      <= '0;
    end else begin
      ack_q <= 1'b0;
      if (word_good && slot_free) begin
        flit_q      <= rx_word[WORD_W-1:CRC_W];
        dst_valid_q <= 1'b1;
        ack_q       <= 1'b1;
      end else if (dst_ready) begin
        dst_valid_q <= 1'b0;
      end
    end
  end

  assign ack_out   = ack_q;
  assign dst_valid = dst_valid_q;
  assign dst_flit  = flit_q;

  // R5: a word that fails the check is never acknowledged
  p_bad_dropped_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && (residue != '0)) |=> !ack_out);
  // R4: an acknowledge always comes with a delivered flit
  p_ack_delivers_r4: assert property (@(posedge clk) disable iff (rst)
    ack_out |-> dst_valid);
  // R11: a stalled output holds its flit
  p_hold_stalled_r11: assert property (@(posedge clk) disable iff (rst)
    (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_flit)));
endmodule

// File: rtl/e2e_crc_link.sv
module e2e_crc_link #(
  parameter int FLIT_W = 128,
  parameter int CRC_W  = 8,
  parameter logic [CRC_W-1:0] POLY = 8'h9B,
  parameter int TMO_W  = 16,
  localparam int WORD_W = FLIT_W + CRC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TMO_W-1:0]  timeout_cycles,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [FLIT_W-1:0] src_flit,
  output logic              net_tx_valid,
  output logic [WORD_W-1:0] net_tx_word,
  input  logic              net_rx_valid,
  input  logic [WORD_W-1:0] net_rx_word,
  output logic              ack_out,
  input  logic              ack_in,
  output logic              dst_valid,
  input  logic              dst_ready,
  output logic [FLIT_W-1:0] dst_flit,
  output logic              vraise_req
);
  link_sender #(.FLIT_W(FLIT_W), .CRC_W(CRC_W), .POLY(POLY), .TMO_W(TMO_W)) u_tx (
    .clk            (clk),
    .rst            (rst),
    .timeout_cycles (timeout_cycles),
    .src_valid      (src_valid),
    .src_ready      (src_ready),
    .src_flit       (src_flit),
    .tx_valid       (net_tx_valid),
    .tx_word        (net_tx_word),
    .ack_in         (ack_in),
    .vraise         (vraise_req)
  );

  link_receiver #(.FLIT_W(FLIT_W), .CRC_W(CRC_W), .POLY(POLY)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (net_rx_valid),
    .rx_word   (net_rx_word),
    .ack_out   (ack_out),
    .dst_valid (dst_valid),
    .dst_ready (dst_ready),
    .dst_flit  (dst_flit)
  );

  // R1: nothing is launched, delivered or requested during reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (src_ready && !net_tx_valid && !dst_valid && !ack_out && !vraise_req));
endmodule

// File: tb/sim_e2e_crc_link.sv
`timescale 1ns/1ps
module sim_e2e_crc_link;
  logic         clk = 1'b0;
  logic         rst;
  logic [15:0]  timeout_cycles;
  logic         src_valid;
  logic         src_ready;
  logic [127:0] src_flit;
  logic         net_tx_valid;
  logic [135:0] net_tx_word;
  logic         net_rx_valid;
  logic [135:0] net_rx_word;
  logic         ack_out;
  logic         ack_in;
  logic         dst_valid;
  logic         dst_ready;
  logic [127:0] dst_flit;
  logic         vraise_req;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  e2e_crc_link u0 (
    .clk(clk), .rst(rst), .timeout_cycles(timeout_cycles),
    .src_valid(src_valid), .src_ready(src_ready), .src_flit(src_flit),
    .net_tx_valid(net_tx_valid), .net_tx_word(net_tx_word),
    .net_rx_valid(net_rx_valid), .net_rx_word(net_rx_word),
    .ack_out(ack_out), .ack_in(ack_in),
    .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_flit(dst_flit),
    .vraise_req(vraise_req)
  );

  // Reference checksum by polynomial long division of flit * x^8.
  function automatic logic [7:0] ref_crc(input logic [127:0] f);
    logic [135:0] r;
    r = {f, 8'h00};
    for (int i = 135; i >= 8; i--)
      if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h19B;
    return r[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [135:0] act,
                     input logic [135:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Launch a flit; returns at the sample where the word is on the network.
  task automatic launch(input logic [127:0] f);
    src_valid = 1'b1;
    src_flit  = f;
    tick();
    src_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(src_ready == 1'b1, "R1 src_ready", 136'(src_ready), 136'd1);
    chk({net_tx_valid, dst_valid, ack_out, vraise_req} == 4'b0, "R1 outputs idle",
        136'({net_tx_valid, dst_valid, ack_out, vraise_req}), 136'd0);
  endtask

  task automatic t_send_and_ack();
    logic [127:0] f;
    int extra_tx;
    f = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    timeout_cycles = 16'd20;
    launch(f);
    chk(net_tx_valid == 1'b1, "R2 tx_valid", 136'(net_tx_valid), 136'd1);
    chk(net_tx_word == {f, ref_crc(f)}, "R2 word format", net_tx_word, {f, ref_crc(f)});
    chk(src_ready == 1'b0, "R3 ready low", 136'(src_ready), 136'd0);
    extra_tx = 0;
    src_valid = 1'b1;
    src_flit  = ~f;
    for (int k = 1; k <= 3; k++) begin
      tick();
      if (net_tx_valid) extra_tx++;
    end
    src_valid = 1'b0;
    chk(extra_tx == 0 && net_tx_word == {f, ref_crc(f)}, "R3 busy ignores src",
        net_tx_word, {f, ref_crc(f)});
    ack_in = 1'b1;
    tick();
    ack_in = 1'b0;
    chk(src_ready == 1'b1, "R8 ready after ack", 136'(src_ready), 136'd1);
    extra_tx = 0;
    for (int k = 0; k < 30; k++) begin
      tick();
      if (vraise_req || net_tx_valid) extra_tx++;
    end
    chk(extra_tx == 0, "R8 no raise after ack", 136'(extra_tx), 136'd0);
  endtask

  task automatic t_ack_idle();
    ack_in = 1'b1;
    tick();
    ack_in = 1'b0;
    chk(src_ready && !net_tx_valid && !vraise_req, "R9 idle ack ignored",
        136'({src_ready, net_tx_valid, vraise_req}), 136'b100);
  endtask

  task automatic t_timeout_resend();
    logic [127:0] f;
    int first, second, extra;
    f = 128'hDEAD_BEEF_0000_FFFF_1234_5678_9ABC_DEF0;
    timeout_cycles = 16'd5;
    launch(f);
    first = -1;
    for (int k = 1; k <= 8 && first < 0; k++) begin
      tick();
      if (vraise_req) first = k;
    end
    chk(first == 5, "R6 first raise at T", 136'(first), 136'd5);
    tick();
    chk(net_tx_valid && !vraise_req && net_tx_word == {f, ref_crc(f)}, "R7 resend same word",
        net_tx_word, {f, ref_crc(f)});
    second = -1;
    for (int k = 1; k <= 8 && second < 0; k++) begin
      tick();
      if (vraise_req) second = k;
    end
    chk(second == 5, "R7 raise repeats", 136'(second), 136'd5);
    tick();
    chk(net_tx_valid == 1'b1, "R7 second resend", 136'(net_tx_valid), 136'd1);
    ack_in = 1'b1;
    tick();
    ack_in = 1'b0;
    extra = 0;
    for (int k = 0; k < 15; k++) begin
      tick();
      if (vraise_req || net_tx_valid) extra++;
    end
    chk(extra == 0 && src_ready, "R8 retry stops after ack", 136'(extra), 136'd0);
  endtask

  task automatic t_ack_on_expiry();
    timeout_cycles = 16'd6;
    launch(128'h5555_AAAA_5555_AAAA_0F0F_F0F0_3C3C_C3C3);
    for (int k = 1; k <= 5; k++) tick();
    ack_in = 1'b1;
    tick();
    ack_in = 1'b0;
    chk(!vraise_req && src_ready, "R8 ack wins over expiry",
        136'({vraise_req, src_ready}), 136'b01);
    tick();
    chk(!net_tx_valid && !vraise_req, "R8 no resend after collision",
        136'({net_tx_valid, vraise_req}), 136'd0);
  endtask

  task automatic t_zero_timeout();
    timeout_cycles = 16'd0;
    launch(128'h1);
    tick();
    chk(vraise_req == 1'b1, "R10 zero acts as one", 136'(vraise_req), 136'd1);
    tick();
    chk(net_tx_valid == 1'b1, "R10 resend", 136'(net_tx_valid), 136'd1);
    ack_in = 1'b1;
    tick();
    ack_in = 1'b0;
    chk(src_ready == 1'b1, "R10 released", 136'(src_ready), 136'd1);
  endtask

  task automatic rx_send(input logic [135:0] w);
    net_rx_valid = 1'b1;
    net_rx_word  = w;
    tick();
    net_rx_valid = 1'b0;
  endtask

  task automatic t_rx_good();
    logic [127:0] pats [4];
    pats[0] = '0;
    pats[1] = '1;
    pats[2] = 128'h8000_0000_0000_0000_0000_0000_0000_0001;
    pats[3] = 128'hC001_D00D_FACE_B00C_0BAD_CAFE_1357_9BDF;
    dst_ready = 1'b1;
    foreach (pats[p]) begin
      rx_send({pats[p], ref_crc(pats[p])});
      chk(dst_valid && ack_out && dst_flit == pats[p], "R4 good delivered",
          136'(dst_flit), 136'(pats[p]));
      tick();
      chk(!ack_out && !dst_valid, "R4 ack one cycle", 136'({ack_out, dst_valid}), 136'd0);
    end
  endtask

  task automatic t_rx_bad();
    logic [127:0] f;
    logic [135:0] w;
    f = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
    dst_ready = 1'b1;
    for (int m = 0; m < 3; m++) begin
      w = {f, ref_crc(f)};
      if (m == 0) w[77] = ~w[77];
      else if (m == 1) w[3] = ~w[3];
      else w[60 +: 8] = ~w[60 +: 8];
      rx_send(w);
      chk(!ack_out && !dst_valid, "R5 corrupt dropped", 136'({ack_out, dst_valid}), 136'd0);
      tick();
      chk(!ack_out && !dst_valid, "R5 no late ack", 136'({ack_out, dst_valid}), 136'd0);
    end
  endtask

  task automatic t_rx_hold();
    logic [127:0] a, b;
    a = 128'hAAAA_0000_1111_2222_3333_4444_5555_6666;
    b = 128'h7777_8888_9999_BBBB_CCCC_DDDD_EEEE_FFFF;
    dst_ready = 1'b0;
    rx_send({a, ref_crc(a)});
    chk(dst_valid && dst_flit == a, "R11 first delivered", 136'(dst_flit), 136'(a));
    rx_send({b, ref_crc(b)});
    chk(dst_valid && dst_flit == a && !ack_out, "R11 held, second dropped",
        136'(dst_flit), 136'(a));
    dst_ready = 1'b1;
    tick();
    chk(!dst_valid, "R11 released", 136'(dst_valid), 136'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    timeout_cycles = 16'd20;
    src_valid = 1'b0;
    src_flit = '0;
    net_rx_valid = 1'b0;
    net_rx_word = '0;
    ack_in = 1'b0;
    dst_ready = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_send_and_ack();
    t_ack_idle();
    t_timeout_resend();
    t_ack_on_expiry();
    t_zero_timeout();
    t_rx_good();
    t_rx_bad();
    t_rx_hold();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule